// File: doc/BRIEF.md
# Dual-Mode SPI Serial Clock Divider

This block derives the serial clock of an SPI controller from the module clock. One configuration word holds two divisor fields and a law-select bit. With the select bit set, the serial clock runs at the module clock divided by 2·(N+1), where N is an 8-bit value. With the bit clear, it runs at the module clock divided by 2^E, where E is a 4-bit exponent. The linear law reaches a divide of 512 at most, so slower rates need the power-of-two law.

The block has three outputs. `sck` is a square wave. `edge_tick` is a one-cycle pulse at every serial clock edge, which paces the shift engine. `edge_lead` marks which of those pulses are leading edges. While no transfer is active, the counter stays cleared, `sck` sits at the requested idle level and no pulses are produced. A configuration write during a transfer is held in a shadow until the current half-period ends, so no half-period is ever shortened. An asynchronous active-low reset is synchronised inside the block before it releases the logic.

Top module: `spi_sck_divider`

## Requirements
- R1: With bit 12 of the configuration word set to 1 (linear law), consecutive `edge_tick` pulses during a transfer are N+1 module-clock cycles apart, N being bits 7:0. The first pulse comes N+1 cycles after the transfer starts.
- R2: With bit 12 set to 0 (power-of-two law) and the exponent E in bits 11:8 between 1 and 15, the pulse spacing is 2^(E-1) cycles, which gives a serial clock of module clock / 2^E.
- R3: Under the power-of-two law with E = 0, `edge_tick` is high in every cycle of a transfer.
- R4: Only the field selected by bit 12 sets the spacing. The field that is not selected has no effect.
- R5: `sck` inverts in the cycle after each `edge_tick` pulse and holds its value in every other cycle of a transfer.
- R6: `edge_lead` is high on the 1st, 3rd, 5th … pulse after a transfer starts and low on the others. It is never high without `edge_tick`.
- R7: While `xfer_active` is low, `edge_tick` and `edge_lead` stay low and `sck` takes the value of `idle_level` one cycle later. A new transfer restarts the count from zero.
- R8: A configuration write during a transfer takes effect only after the current half-period has run its full length.
- R9: After reset the configuration word is zero (power-of-two law, E = 0), `sck` is 0 and no pulse is produced.
- R10: Under the linear law N = 255 gives a 256-cycle pulse spacing, which is a divide of 512.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 13 | Configuration word: [7:0] linear N, [11:8] exponent E, [12] law select (1 = linear) |
| xfer_active | input | 1 | High while a transfer runs; low holds the divider cleared |
| idle_level | input | 1 | Level that `sck` takes while idle |
| sck | output | 1 | Serial clock |
| edge_tick | output | 1 | One-cycle pulse at each serial clock edge |
| edge_lead | output | 1 | High on pulses that are leading edges |

## Verification
The bench checks both ends of each law. At E = 0 and N = 0 a pulse is due every cycle, and a design with an off-by-one limit would skip cycles there. At E = 15 and N = 255 the spacing is at its longest, and a counter that is too narrow would wrap early and produce short half-periods. The bench writes a new divisor in the middle of a half-period: a design that reloads at once would end that half-period early instead of letting it run its full ten cycles. The bench also stops a transfer after one edge and starts another. A divider that did not clear its count or phase would then start at a shifted first edge, leave `sck` off its idle level, or report a trailing edge as leading.

// File: rtl/sckdiv_pkg.sv
package sckdiv_pkg;
  // field widths of the configuration word
  localparam int unsigned LIN_W = 8;
  localparam int unsigned EXP_W = 4;
  localparam int unsigned CFG_W = LIN_W + EXP_W + 1;
  // largest power-of-two half-period limit is 2^(2^EXP_W-2)-1
  localparam int unsigned POW_W = (2 ** EXP_W) - 2;
  localparam int unsigned CNT_W = (LIN_W > POW_W) ? LIN_W : POW_W;

  typedef struct packed {
    logic             lin_mode;
    logic [EXP_W-1:0] exp_n;
    logic [LIN_W-1:0] lin_n;
  } sckdiv_cfg_t;
endpackage

// File: rtl/sckdiv_limit.sv
module sckdiv_limit
  import sckdiv_pkg::*;
(
  input  sckdiv_cfg_t      cfg,
  output logic [CNT_W-1:0] lim
);
  // lim = half-period length minus one
  always_comb begin
    lim = '0;
    if (cfg.lin_mode) begin
      lim = CNT_W'(cfg.lin_n);
    end else begin
      // 2^(E-1)-1: bits 0..E-2 set; E = 0 and E = 1 both give zero
      for (int i = 0; i < CNT_W; i++) begin
        lim[i] = ((i + 1) < int'(cfg.exp_n));
      end
    end
  end
endmodule

// File: rtl/sckdiv_shadow.sv
module sckdiv_shadow
  import sckdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  input  logic             active,
  input  logic             wrap,
  output sckdiv_cfg_t      eff
);
  sckdiv_cfg_t cfg_q, cfg_d;
  sckdiv_cfg_t eff_q, eff_d;
  logic        cfg_en, eff_en;

  always_comb begin
    cfg_en = wr;
    cfg_d  = sckdiv_cfg_t'(wdata);
    // reload only while idle or at the end of a half-period
    eff_en = !active || wrap;
    eff_d  = wr ? sckdiv_cfg_t'(wdata) : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      eff_q <= '0;
    end else begin
      if (cfg_en) cfg_q <= cfg_d;
      if (eff_en) eff_q <= eff_d;
    end
  end

  assign eff = eff_q;

  // R8
  eff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !wrap) |=> $stable(eff_q));

  // R7
  idle_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && wr) |=> (eff_q == sckdiv_cfg_t'($past(wdata))));
endmodule

// File: rtl/sckdiv_count.sv
module sckdiv_count
  import sckdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             idle_level,
  input  logic [CNT_W-1:0] lim,
  output logic             sck,
  output logic             tick,
  output logic             lead
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sck_q, sck_d;
  logic             phase_q, phase_d;

  assign tick = active && (cnt_q == lim);
  assign lead = tick && !phase_q;

  always_comb begin
    cnt_d   = cnt_q + 1'b1;
    sck_d   = sck_q;
    phase_d = phase_q;
    if (!active) begin
      cnt_d   = '0;
      sck_d   = idle_level;
      phase_d = 1'b0;
    end else if (tick) begin
      cnt_d   = '0;
      sck_d   = !sck_q;
      phase_d = !phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sck_q   <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      sck_q   <= sck_d;
      phase_q <= phase_d;
    end
  end

  assign sck = sck_q;

  // R1
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim);

  // R5
  sck_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (sck_q != $past(sck_q)));

  // R5
  sck_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick) |=> $stable(sck_q));

  // R7
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (sck_q == $past(idle_level)));
endmodule

// File: rtl/spi_sck_divider.sv
module spi_sck_divider
  import sckdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             xfer_active,
  input  logic             idle_level,
  output logic             sck,
  output logic             edge_tick,
  output logic             edge_lead
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  sckdiv_cfg_t      eff_cfg;
  logic [CNT_W-1:0] half_lim;
  logic             tick_w;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sckdiv_shadow u_shadow (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr     (cfg_wr),
    .wdata  (cfg_wdata),
    .active (xfer_active),
    .wrap   (tick_w),
    .eff    (eff_cfg)
  );

  sckdiv_limit u_limit (
    .cfg (eff_cfg),
    .lim (half_lim)
  );

  sckdiv_count u_count (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .active     (xfer_active),
    .idle_level (idle_level),
    .lim        (half_lim),
    .sck        (sck),
    .tick       (tick_w),
    .lead       (edge_lead)
  );

  assign edge_tick = tick_w;

  // R7
  tick_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    edge_tick |-> xfer_active);

  // R6
  lead_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    edge_lead |-> edge_tick);
endmodule

// File: tb/spi_sck_divider_tb.sv
module spi_sck_divider_tb;
  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic [12:0] cfg_wdata;
  logic        xfer_active;
  logic        idle_level;
  logic        sck;
  logic        edge_tick;
  logic        edge_lead;

  int n_checks = 0;
  int n_fails  = 0;

  spi_sck_divider u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .cfg_wdata   (cfg_wdata),
    .xfer_active (xfer_active),
    .idle_level  (idle_level),
    .sck         (sck),
    .edge_tick   (edge_tick),
    .edge_lead   (edge_lead)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [12:0] mk(input logic lin, input int e, input int n);
    return {lin, 4'(e), 8'(n)};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [12:0] v);
    @(negedge clk);
    cfg_wr    = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_wr    = 1'b0;
  endtask

  // run a transfer and compare tick, sck and lead to the expected pattern
  task automatic run_seq(input string req, input int h, input int nt);
    int ft = 0, fs = 0, fl = 0;
    int at = 0, et = 0, as_ = 0, es = 0, al = 0, el = 0;
    logic xt, xs, xl;
    @(negedge clk);
    xfer_active = 1'b1;
    for (int s = 1; s <= h * nt; s++) begin
      if (s > 1) @(negedge clk);
      #1;
      xt = ((s % h) == 0);
      xs = idle_level ^ (((s - 1) / h) % 2 == 1);
      xl = xt && ((s / h) % 2 == 1);
      if (edge_tick !== xt && ft == 0) begin ft = s; at = int'(edge_tick); et = int'(xt); end
      if (sck !== xs && fs == 0)       begin fs = s; as_ = int'(sck);     es = int'(xs); end
      if (edge_lead !== xl && fl == 0) begin fl = s; al = int'(edge_lead); el = int'(xl); end
    end
    @(negedge clk);
    xfer_active = 1'b0;
    chk(req, $sformatf("tick spacing h=%0d (first bad sample %0d)", h, ft), at, et);
    chk({req, "/R5"}, $sformatf("sck level h=%0d (first bad sample %0d)", h, fs), as_, es);
    chk({req, "/R6"}, $sformatf("lead flag h=%0d (first bad sample %0d)", h, fl), al, el);
  endtask

  task automatic t_reset;
    #1;
    chk("R9", "sck in reset", int'(sck), 0);
    chk("R9", "tick in reset", int'(edge_tick), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R9", "sck after reset", int'(sck), 0);
    chk("R9", "tick after reset", int'(edge_tick), 0);
    chk("R9", "lead after reset", int'(edge_lead), 0);
    run_seq("R9", 1, 4);
  endtask

  task automatic t_linear;
    write_cfg(mk(1'b1, 0, 0));  run_seq("R1", 1, 4);
    write_cfg(mk(1'b1, 0, 3));  run_seq("R1", 4, 4);
    write_cfg(mk(1'b1, 9, 6));  run_seq("R1", 7, 3);
  endtask

  task automatic t_linear_max;
    write_cfg(mk(1'b1, 0, 255));
    run_seq("R10", 256, 3);
  endtask

  task automatic t_pow2;
    write_cfg(mk(1'b0, 1, 0));   run_seq("R2", 1, 4);
    write_cfg(mk(1'b0, 4, 77));  run_seq("R2", 8, 4);
    write_cfg(mk(1'b0, 15, 0));  run_seq("R2", 16384, 2);
  endtask

  task automatic t_pow2_zero;
    write_cfg(mk(1'b0, 0, 200));
    run_seq("R3", 1, 6);
  endtask

  task automatic t_select;
    write_cfg(mk(1'b1, 5, 3));  run_seq("R4", 4, 3);
    write_cfg(mk(1'b0, 5, 3));  run_seq("R4", 16, 3);
  endtask

  task automatic t_idle_restart;
    idle_level = 1'b1;
    write_cfg(mk(1'b1, 0, 2));
    repeat (2) @(negedge clk);
    #1;
    chk("R7", "sck follows idle level", int'(sck), 1);
    run_seq("R7", 3, 4);
    write_cfg(mk(1'b1, 0, 4));
    @(negedge clk);
    xfer_active = 1'b1;
    repeat (6) @(negedge clk);
    xfer_active = 1'b0;
    #1;
    chk("R7", "tick while idle", int'(edge_tick), 0);
    @(negedge clk);
    #1;
    chk("R7", "sck back at idle", int'(sck), 1);
    chk("R7", "lead while idle", int'(edge_lead), 0);
    run_seq("R7", 5, 3);
    idle_level = 1'b0;
    write_cfg(mk(1'b1, 0, 0));
  endtask

  task automatic t_midwrite;
    int fb = 0, a = 0, e = 0;
    logic xt;
    write_cfg(mk(1'b1, 0, 9));
    @(negedge clk);
    xfer_active = 1'b1;
    for (int s = 1; s <= 16; s++) begin
      if (s > 1) @(negedge clk);
      if (s == 4) begin cfg_wr = 1'b1; cfg_wdata = mk(1'b1, 0, 1); end
      if (s == 5) cfg_wr = 1'b0;
      #1;
      xt = (s == 10) || (s == 12) || (s == 14) || (s == 16);
      if (edge_tick !== xt && fb == 0) begin fb = s; a = int'(edge_tick); e = int'(xt); end
    end
    @(negedge clk);
    xfer_active = 1'b0;
    chk("R8", $sformatf("deferred reload (first bad sample %0d)", fb), a, e);
  endtask

  initial begin
    #600us;
    n_fails++;
    n_checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    cfg_wr      = 1'b0;
    cfg_wdata   = '0;
    xfer_active = 1'b0;
    idle_level  = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_linear();
    t_linear_max();
    t_pow2();
    t_pow2_zero();
    t_select();
    t_idle_restart();
    t_midwrite();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule